// File: doc/BRIEF.md
# Rate-2/3 (1,7) Run-Length-Limited Write Encoder

This block forms the write half of a disk-channel encoder/decoder. A controller shifts serial NRZ data into it, one bit per strobe, and the block turns each two-bit data pair into a three-bit channel word. The block runs on a single clock at the channel-bit rate, which is three times the data-pair rate. Each cycle it emits one channel bit, where a one marks a flux transition. It looks one data pair ahead and replaces selected pair combinations with six-bit words. This keeps at least one and at most seven zeros between any two channel ones, even across word boundaries.

Two extra controls shape what reaches the write head. A DC-erase input blanks the channel stream at once, so no transitions are written. A precompensation enable marks each channel one whose nearest neighbour lies at minimum spacing on one side only. The mark is an early or late flag that a downstream delay element can act on. Dropping the write gate silences the output and discards every buffered bit, so each burst starts from a clean state.

The core is a five-state machine. IDLE is held while the write gate is low, and raising the gate moves it to FILL. FILL waits until two data pairs are queued. At every word boundary a decision picks the next state. BASIC emits the mapped word of one pair. SUBHEAD emits the first word of a two-pair substitution and is always followed by SUBTAIL, which emits three zeros. If fewer than two pairs are queued at a boundary, the machine returns to FILL. A low write gate sends any state back to IDLE.

Top module: `rll17_write_encoder`

## Requirements
- R1: With the write gate first sampled high on edge 1, and data bits sampled on edges 3j+1 and 3j+2 for pair j, channel bit k of the burst appears on code_bit after edge 9+k. Channel bits follow back to back, one per cycle, and code_bit is low after edges 1 to 8.
- R2: When no substitution applies, a pair maps to a word: 00 gives 101, 01 gives 100, 10 gives 001, 11 gives 010.
- R3: A pair ending in 0, followed by a pair starting with 0, is encoded as one six-bit word: 0000 gives 101000, 0001 gives 100000, 1000 gives 001000, 1001 gives 010000. The following pair is then encoded fresh.
- R4: Within a burst, every two channel ones on code_bit have at least one and at most seven zeros between them.
- R5: The first data bit received is the left bit of a pair, and the left bit of each channel word is sent first.
- R6: With precompensation enabled, pc_early is high together with a channel one whose one two bits earlier is present and whose one two bits later is absent.
- R7: With precompensation enabled, pc_late is high together with a channel one whose one two bits later is present and whose one two bits earlier is absent.
- R8: With precompensation disabled, pc_early and pc_late stay low.
- R9: While erase is high, code_bit, pc_early and pc_late are low in the same cycle. Encoding continues underneath, so the stream resumes in step once erase falls.
- R10: While wr_gate is low, all outputs are low in the same cycle. The queued pairs, any half-received pair and the output pipeline are cleared.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel-bit clock (three cycles per data pair) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_gate | input | 1 | Write enable; low idles and clears the block |
| nrz_bit | input | 1 | Serial NRZ data bit |
| nrz_valid | input | 1 | Strobe: nrz_bit is taken on this edge |
| erase | input | 1 | DC-erase override; blanks all outputs |
| pcomp_en | input | 1 | Enables the precompensation flags |
| code_bit | output | 1 | Serial channel bit, one marks a transition |
| pc_early | output | 1 | Current channel one needs an early shift |
| pc_late | output | 1 | Current channel one needs a late shift |

## Verification
The encoder is driven with long runs of zero pairs, which substitute on every pair boundary. It is also driven with all-one pairs, which only ever use the basic map, and with alternating bits. A crafted sequence places each of the four substitution cases between plain pairs, and a pseudo-random stream mixes everything. Each observed stream is compared bit by bit with a model built from the mapping tables, so a wrong word, a wrong substitution trigger or a wrong bit order shows up as a mismatch at a known position. The run-length limits and both precompensation flags are checked on the same streams, with precompensation enabled and disabled. An erase window placed mid-stream checks that the outputs blank and then resume in step. A burst cut off mid-pair and followed by a fresh burst tells a real clear apart from leftover queued data.

// File: rtl/rll17_pkg.sv
package rll17_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_BASIC,
        ST_SUBHEAD,
        ST_SUBTAIL
    } enc_state_t;

    // Plain three-bit word for one data pair (left bit sent first).
    function automatic logic [2:0] pair_word(input logic [1:0] pr);
        logic [2:0] w;
        unique case (pr)
            2'b00:   w = 3'b101;
            2'b01:   w = 3'b100;
            2'b10:   w = 3'b001;
            default: w = 3'b010;
        endcase
        return w;
    endfunction

    // A pair ending in 0 followed by a pair starting with 0 would place
    // two ones side by side, so the pair is merged with its successor.
    function automatic logic merge_needed(input logic [1:0] cur, input logic [1:0] nxt);
        return (cur[0] == 1'b0) && (nxt[1] == 1'b0);
    endfunction

    // Leading word of a merged pair: picked from the outer data bits.
    function automatic logic [2:0] merge_head(input logic [1:0] cur, input logic [1:0] nxt);
        return pair_word({cur[1], nxt[0]});
    endfunction

endpackage

// File: rtl/nrz_pair_queue.sv
module nrz_pair_queue #(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_in,
    input  logic          bit_vld,
    input  logic [1:0]    pop_cnt,
    output logic [1:0]    head0,
    output logic [1:0]    head1,
    output logic [CW-1:0] avail
);

    logic [1:0]    slot   [DEPTH];
    logic [1:0]    slot_n [DEPTH];
    logic          half_v;
    logic          half_b;
    logic          push;
    logic [CW-1:0] after_pop;
    logic [CW-1:0] avail_n;

    assign push  = bit_vld && half_v;
    assign head0 = slot[0];
    assign head1 = slot[1];

    always_comb begin
        after_pop = avail - CW'(pop_cnt);
        avail_n   = after_pop;
        for (int i = 0; i < DEPTH; i++) begin
            slot_n[i] = (i + int'(pop_cnt) < DEPTH) ? slot[i + int'(pop_cnt)] : 2'b00;
        end
        if (push && (int'(after_pop) < DEPTH)) begin
            slot_n[after_pop] = {half_b, bit_in};
            avail_n           = after_pop + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_v <= 1'b0;
            half_b <= 1'b0;
            avail  <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= 2'b00;
        end else if (clr) begin
            half_v <= 1'b0;
            half_b <= 1'b0;
            avail  <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= 2'b00;
        end else begin
            if (bit_vld) begin
                half_v <= !half_v;
                if (!half_v) half_b <= bit_in;
            end
            avail <= avail_n;
            for (int i = 0; i < DEPTH; i++) slot[i] <= slot_n[i];
        end
    end

endmodule

// File: rtl/rll17_code_fsm.sv
module rll17_code_fsm
    import rll17_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate,
    input  logic [CW-1:0] avail,
    input  logic [1:0]    head0,
    input  logic [1:0]    head1,
    output logic [1:0]    pop_cnt,
    output logic          raw_bit
);

    enc_state_t state, state_n;
    logic [1:0] ph, ph_n;
    logic [2:0] word, word_n;
    logic       emitting;
    logic       at_bound;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= 2'd0;
            word  <= 3'b000;
        end else begin
            state <= state_n;
            ph    <= ph_n;
            word  <= word_n;
        end
    end

    // Next-state and word-selection process.
    always_comb begin
        state_n  = state;
        word_n   = word;
        ph_n     = (ph == 2'd2) ? 2'd0 : ph + 2'd1;
        pop_cnt  = 2'd0;
        emitting = (state == ST_BASIC) || (state == ST_SUBHEAD) || (state == ST_SUBTAIL);
        at_bound = (state == ST_FILL) || (emitting && (ph == 2'd2));
        unique case (state)
            ST_IDLE: begin
                state_n = ST_FILL;
                ph_n    = 2'd0;
            end
            ST_FILL, ST_BASIC, ST_SUBHEAD, ST_SUBTAIL: begin
                if (at_bound) begin
                    ph_n = 2'd0;
                    if (state == ST_SUBHEAD) begin
                        state_n = ST_SUBTAIL;
                        word_n  = 3'b000;
                    end else if (avail >= CW'(2)) begin
                        if (merge_needed(head0, head1)) begin
                            state_n = ST_SUBHEAD;
                            word_n  = merge_head(head0, head1);
                            pop_cnt = 2'd2;
                        end else begin
                            state_n = ST_BASIC;
                            word_n  = pair_word(head0);
                            pop_cnt = 2'd1;
                        end
                    end else begin
                        state_n = ST_FILL;
                        word_n  = 3'b000;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (!gate) begin
            state_n = ST_IDLE;
            ph_n    = 2'd0;
            word_n  = 3'b000;
            pop_cnt = 2'd0;
        end
    end

    // Output process: one channel bit per cycle, left bit first.
    always_comb begin
        raw_bit = emitting ? word[2'd2 - ph] : 1'b0;
    end

endmodule

// File: rtl/precomp_shaper.sv
module precomp_shaper #(
    parameter int SPAN = 2,
    localparam int W   = 2 * SPAN + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw_bit,
    input  logic pc_en,
    input  logic blank,
    output logic code_bit,
    output logic pc_early,
    output logic pc_late
);

    // win[W-1] is the oldest bit, win[SPAN] is the bit being sent.
    logic [W-1:0] win;
    logic         centre;
    logic         near_before;
    logic         near_after;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   win <= '0;
        else if (clr) win <= '0;
        else          win <= {win[W-2:0], raw_bit};
    end

    assign centre      = win[SPAN] && !blank;
    assign near_before = win[W-1];
    assign near_after  = win[0];

    assign code_bit = centre;
    assign pc_early = centre && pc_en && near_before && !near_after;
    assign pc_late  = centre && pc_en && near_after && !near_before;

endmodule

// File: rtl/rll17_write_encoder.sv
module rll17_write_encoder #(
    parameter int PAIR_DEPTH = 4,
    localparam int CW        = $clog2(PAIR_DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_gate,
    input  logic nrz_bit,
    input  logic nrz_valid,
    input  logic erase,
    input  logic pcomp_en,
    output logic code_bit,
    output logic pc_early,
    output logic pc_late
);

    logic [1:0]    head0;
    logic [1:0]    head1;
    logic [CW-1:0] avail;
    logic [1:0]    pop_cnt;
    logic          raw_bit;

    nrz_pair_queue #(.DEPTH(PAIR_DEPTH), .CW(CW)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!wr_gate),
        .bit_in  (nrz_bit),
        .bit_vld (nrz_valid),
        .pop_cnt (pop_cnt),
        .head0   (head0),
        .head1   (head1),
        .avail   (avail)
    );

    rll17_code_fsm #(.CW(CW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (wr_gate),
        .avail   (avail),
        .head0   (head0),
        .head1   (head1),
        .pop_cnt (pop_cnt),
        .raw_bit (raw_bit)
    );

    precomp_shaper #(.SPAN(2)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!wr_gate),
        .raw_bit  (raw_bit),
        .pc_en    (pcomp_en),
        .blank    (erase || !wr_gate),
        .code_bit (code_bit),
        .pc_early (pc_early),
        .pc_late  (pc_late)
    );

endmodule

// File: rtl/rll17_enc_checker.sv
module rll17_enc_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_gate,
    input logic erase,
    input logic pcomp_en,
    input logic code_bit,
    input logic pc_early,
    input logic pc_late
);

    // R4: never two channel ones in adjacent cycles.
    assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_bit |=> !code_bit);

    // R6 / R7: a flag only accompanies a channel one, never both at once.
    assert_flag_on_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_early || pc_late) |-> (code_bit && !(pc_early && pc_late)));

    // R6: an early flag needs a one sent two cycles before, unless it was blanked.
    assert_early_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_early |-> ($past(code_bit, 2) || $past(erase, 2)));

    // R8: flags stay low with precompensation off.
    assert_pcomp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pcomp_en |-> (!pc_early && !pc_late));

    // R10: a low write gate clears the pipeline, so the next cycle is silent too.
    assert_gate_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gate |=> !code_bit);

endmodule

bind rll17_write_encoder rll17_enc_checker u_chk (.*);

// File: tb/sim_rll17_write_encoder.sv
`timescale 1ns/1ps
module sim_rll17_write_encoder;

    logic clk = 1'b0;
    logic rst_n;
    logic wr_gate, nrz_bit, nrz_valid, erase, pcomp_en;
    logic code_bit, pc_early, pc_late;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [1:0] pat [0:63];
    int         cref [0:255];

    always #2.5 clk = !clk;

    rll17_write_encoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_gate(wr_gate), .nrz_bit(nrz_bit),
        .nrz_valid(nrz_valid), .erase(erase), .pcomp_en(pcomp_en),
        .code_bit(code_bit), .pc_early(pc_early), .pc_late(pc_late)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic int word_of(input logic [1:0] p);
        case (p)
            2'b00:   return 5;
            2'b01:   return 4;
            2'b10:   return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int cbit(input int k, input int len);
        if (k < 0 || k >= len) return 0;
        return cref[k];
    endfunction

    task automatic drive_for(input int e, input int np);
        int j = (e - 1) / 3;
        int r = (e - 1) % 3;
        if (r < 2 && j < np) begin
            nrz_valid = 1'b1;
            nrz_bit   = pat[j][1 - r];
        end else begin
            nrz_valid = 1'b0;
            nrz_bit   = 1'b0;
        end
    endtask

    // Runs one burst of np pairs; erase is high for samples ea..eb.
    task automatic run_stream(input int np, input bit pc, input int ea, input int eb);
        int len = 0;
        int i   = 0;
        int last_one = -1;
        while (i < np - 1) begin
            int w;
            if (!pat[i][0] && !pat[i + 1][1]) begin
                w = word_of({pat[i][1], pat[i + 1][0]});
                for (int b = 2; b >= 0; b--) begin cref[len] = (w >> b) & 1; len++; end
                for (int b = 0; b < 3; b++) begin cref[len] = 0; len++; end
                i += 2;
            end else begin
                w = word_of(pat[i]);
                for (int b = 2; b >= 0; b--) begin cref[len] = (w >> b) & 1; len++; end
                i += 1;
            end
        end
        pcomp_en = pc;
        wr_gate  = 1'b1;
        erase    = (ea <= 1 && eb >= 1);
        drive_for(1, np);
        for (int n = 1; n <= 9 + len; n++) begin
            int k = n - 9;
            bit er = (n >= ea && n <= eb);
            @(negedge clk);
            if (k < 0) begin
                check("R1 lead-in silence", int'(code_bit), 0);
            end else if (k < len - 2) begin
                int ec = er ? 0 : cref[k];
                int ee = (!er && pc) ? (cbit(k, len) & cbit(k - 2, len) & (1 - cbit(k + 2, len))) : 0;
                int el = (!er && pc) ? (cbit(k, len) & cbit(k + 2, len) & (1 - cbit(k - 2, len))) : 0;
                check(er ? "R9 erase blanks code" : "R1 R2 R3 R5 code stream", int'(code_bit), ec);
                check(pc ? "R6 early flag" : "R8 early off", int'(pc_early), ee);
                check(pc ? "R7 late flag" : "R8 late off", int'(pc_late), el);
                if (ea < 0 && code_bit) begin
                    if (last_one >= 0) begin
                        int gap = k - last_one - 1;
                        check("R4 run length in range", int'(gap >= 1 && gap <= 7), 1);
                    end
                    last_one = k;
                end
            end
            drive_for(n + 1, np);
            erase = ((n + 1) >= ea && (n + 1) <= eb);
        end
        wr_gate   = 1'b0;
        nrz_valid = 1'b0;
        erase     = 1'b0;
        #1;
        check("R10 gate low silences", int'(code_bit | pc_early | pc_late), 0);
        @(negedge clk);
        check("R10 gate low stays silent", int'(code_bit), 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; wr_gate = 1'b0; nrz_bit = 1'b0; nrz_valid = 1'b0;
        erase = 1'b0; pcomp_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset code_bit", int'(code_bit), 0);
        check("R11 reset flags", int'(pc_early | pc_late), 0);
    endtask

    task automatic test_zeros();
        for (int j = 0; j < 16; j++) pat[j] = 2'b00;
        run_stream(16, 1'b1, -1, -2);
    endtask

    task automatic test_ones();
        for (int j = 0; j < 16; j++) pat[j] = 2'b11;
        run_stream(16, 1'b1, -1, -2);
    endtask

    task automatic test_alternate();
        for (int j = 0; j < 16; j++) pat[j] = 2'b01;
        run_stream(16, 1'b0, -1, -2);
    endtask

    task automatic test_merges();
        logic [1:0] seq [0:15] = '{2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01, 2'b11, 2'b10,
                                   2'b00, 2'b11, 2'b10, 2'b01, 2'b11, 2'b11, 2'b01, 2'b10};
        for (int j = 0; j < 16; j++) pat[j] = seq[j];
        run_stream(16, 1'b1, -1, -2);
    endtask

    task automatic test_random(input bit pc, input int ea, input int eb);
        logic [7:0] lf = 8'h5B;
        for (int j = 0; j < 40; j++) begin
            pat[j] = lf[1:0];
            for (int s = 0; s < 2; s++) lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        end
        run_stream(40, pc, ea, eb);
    endtask

    task automatic test_gate_clear();
        wr_gate = 1'b1;
        pcomp_en = 1'b1;
        for (int e = 1; e <= 13; e++) begin
            int r = (e - 1) % 3;
            nrz_valid = (r < 2);
            nrz_bit   = 1'b1;
            @(negedge clk);
        end
        nrz_valid = 1'b0;
        wr_gate   = 1'b0;
        #1;
        check("R10 gate drop silences at once", int'(code_bit | pc_early | pc_late), 0);
        repeat (2) @(negedge clk);
        check("R10 gate low output", int'(code_bit), 0);
        for (int j = 0; j < 12; j++) pat[j] = (j % 3 == 0) ? 2'b10 : 2'b00;
        run_stream(12, 1'b1, -1, -2);
    endtask

    initial begin
        test_reset();
        test_zeros();
        test_ones();
        test_alternate();
        test_merges();
        test_random(1'b1, -1, -2);
        test_random(1'b0, -1, -2);
        test_random(1'b1, 20, 34);
        test_gate_clear();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule